// File: doc/BRIEF.md
# Programmable Clock Divider Cell

This cell derives one output clock from a source clock. It runs on a reference clock at twice the source rate, so one source period is two reference cycles. The output waveform comes from a single registered counter. Its ratio is picked three ways. A fixed divide-by-three path has top priority. After that, a bypass gives ratio one. Otherwise a 3-bit code looks up a ratio in a sparse table. A gate at the output holds the clock low when it is disabled. Ratio changes and gate changes are applied only at safe points in the waveform, so no short pulse can leave the cell.

Software reaches the cell through a small synchronous write/read port. The same port also holds a source-selection state: an "alternate source" bit and a 3-bit alternate-source code. From these the cell forms a source index, which an external clock multiplexer uses. The index can be written directly. The cell then splits it back into the bit and the code.

Top module: `clkdiv_cell`

## Requirements
- R1: After synchronous reset, every field reads 0, `src_index` is 0, `rd_data` is 0 and `clk_out` stays low.
- R2: Register address 1 holds the divider fields: bit 0 is the programmable-enable bit, bits 3:1 are the ratio code, and bit 4 is the divide-by-three bit. With bit 4 clear and bit 0 set, codes 0..7 give source ratios 1, 2, 4, 6, 8, 12, 1, 1.
- R3: With the divide-by-three bit set, the ratio is 3 whatever the other divider bits hold. The output is high for one source period (2 reference cycles) and low for two (4 reference cycles).
- R4: With the divide-by-three bit clear and the programmable-enable bit 0, the ratio is 1: high 1 reference cycle, low 1.
- R5: An even ratio N gives a 50% duty cycle: high N reference cycles, low N.
- R6: A new ratio takes effect only at the next rising edge of the output waveform. A high phase already under way finishes at the old length.
- R7: Register address 2 bit 0 is the gate enable. While it is 0, `clk_out` stays low. The gate state changes only while the waveform is low, so every pulse that leaves the cell has full length.
- R8: Register address 0 holds the source fields: bit 0 is the alternate-source bit and bits 3:1 are the alternate-source code. `src_index` is 0 when the bit is clear, and 1 plus the code when it is set. It updates one cycle after the register.
- R9: A write to address 3 with value 0 clears the alternate-source bit and keeps the code. A value k from 1 to 8 sets the bit and stores k-1 as the code. Values above 8 change nothing.
- R10: A read returns, one cycle after `rd_en`, the value last written to each field, zero-extended. Address 3 reads `src_index`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock, twice the source rate |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 2 | Read address |
| rd_data | output | DW | Registered read data |
| src_index | output | 4 | Decoded source index for the external multiplexer |
| clk_out | output | 1 | Gated divided clock |

## Verification
The hardest case to reach is a ratio change that lands in the middle of a long high phase. Only there can a runt pulse come from applying the new ratio too early. The stimulus waits for a rising edge of a ratio-12 output. It then writes a ratio-2 setting in the very next cycle and measures the whole high phase that follows. Gate disable is reached the same way, with the waveform running. Randomized divider settings and randomized source-index writes, some above the legal range, are then checked against a model kept in the bench.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  localparam int SEL_W     = 3;
  localparam int RATIO_MAX = 12;
  localparam int RATIO_W   = $clog2(RATIO_MAX + 1);
  localparam int CNT_W     = $clog2(2 * RATIO_MAX + 1);
  localparam int IDX_W     = SEL_W + 1;
  localparam int IDX_MAX   = 2 ** SEL_W;
  localparam int REG_AW    = 2;

  localparam logic [REG_AW-1:0] ADDR_SRC  = 2'd0;
  localparam logic [REG_AW-1:0] ADDR_DIV  = 2'd1;
  localparam logic [REG_AW-1:0] ADDR_GATE = 2'd2;
  localparam logic [REG_AW-1:0] ADDR_IDX  = 2'd3;

  // bit 4: divide-by-three, bits 3:1: ratio code, bit 0: programmable enable
  typedef struct packed {
    logic             third;
    logic [SEL_W-1:0] code;
    logic             prog_on;
  } div_cfg_t;

  localparam int CFG_W = $bits(div_cfg_t);

  function automatic logic [RATIO_W-1:0] table_ratio(input logic [SEL_W-1:0] c);
    logic [RATIO_W-1:0] r;
    case (c)
      3'd1:    r = RATIO_W'(2);
      3'd2:    r = RATIO_W'(4);
      3'd3:    r = RATIO_W'(6);
      3'd4:    r = RATIO_W'(8);
      3'd5:    r = RATIO_W'(12);
      default: r = RATIO_W'(1);
    endcase
    return r;
  endfunction

  function automatic logic [RATIO_W-1:0] eff_ratio(input div_cfg_t c);
    logic [RATIO_W-1:0] r;
    if (c.third)         r = RATIO_W'(3);
    else if (!c.prog_on) r = RATIO_W'(1);
    else                 r = table_ratio(c.code);
    return r;
  endfunction

endpackage

// File: rtl/clkdiv_regs.sv
module clkdiv_regs
  import clkdiv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [REG_AW-1:0]   wr_addr,
  input  logic [DW-1:0]       wr_data,
  input  logic                rd_en,
  input  logic [REG_AW-1:0]   rd_addr,
  output logic [DW-1:0]       rd_data,
  output div_cfg_t            cfg,
  output logic                gate_req,
  output logic [IDX_W-1:0]    src_index
);

  logic             alt_on_q;
  logic [SEL_W-1:0] alt_code_q;
  div_cfg_t         cfg_q;
  logic             gate_q;
  logic [IDX_W-1:0] idx_q;
  logic [DW-1:0]    rd_q;
  logic [DW-1:0]    rd_nx;
  logic [DW-1:0]    idx_minus1;
  logic             idx_zero;
  logic             idx_legal;

  assign idx_minus1 = wr_data - DW'(1);
  assign idx_zero   = (wr_data == '0);
  assign idx_legal  = (wr_data <= DW'(IDX_MAX));

  always_ff @(posedge clk) begin
    if (rst) begin
      alt_on_q   <= 1'b0;
      alt_code_q <= '0;
      cfg_q      <= '0;
      gate_q     <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        ADDR_SRC: begin
          alt_on_q   <= wr_data[0];
          alt_code_q <= wr_data[SEL_W:1];
        end
        ADDR_DIV:  cfg_q  <= div_cfg_t'(wr_data[CFG_W-1:0]);
        ADDR_GATE: gate_q <= wr_data[0];
        default: begin
          if (idx_zero) begin
            alt_on_q <= 1'b0;
          end else if (idx_legal) begin
            alt_on_q   <= 1'b1;
            alt_code_q <= idx_minus1[SEL_W-1:0];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) idx_q <= '0;
    else     idx_q <= alt_on_q ? ({1'b0, alt_code_q} + IDX_W'(1)) : '0;
  end

  always_comb begin
    rd_nx = '0;
    case (rd_addr)
      ADDR_SRC: begin
        rd_nx[0]       = alt_on_q;
        rd_nx[SEL_W:1] = alt_code_q;
      end
      ADDR_DIV:  rd_nx[CFG_W-1:0] = cfg_q;
      ADDR_GATE: rd_nx[0]         = gate_q;
      default:   rd_nx[IDX_W-1:0] = idx_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= rd_nx;
  end

  assign rd_data   = rd_q;
  assign cfg       = cfg_q;
  assign gate_req  = gate_q;
  assign src_index = idx_q;

endmodule

// File: rtl/clkdiv_core.sv
module clkdiv_core
  import clkdiv_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  div_cfg_t         cfg,
  output logic             wave,
  output logic [CNT_W-1:0] period_live
);

  logic [RATIO_W-1:0] ratio;
  logic [CNT_W-1:0]   new_period;
  logic [CNT_W-1:0]   new_high;
  logic [CNT_W-1:0]   cnt_q;
  logic [CNT_W-1:0]   cnt_inc;
  logic [CNT_W-1:0]   per_q;
  logic [CNT_W-1:0]   high_q;
  logic               wave_q;
  logic               wrap;

  // one source period is two reference cycles
  assign ratio      = eff_ratio(cfg);
  assign new_period = CNT_W'(ratio) << 1;
  assign new_high   = (ratio == RATIO_W'(3)) ? CNT_W'(2) : CNT_W'(ratio);
  assign cnt_inc    = cnt_q + CNT_W'(1);
  assign wrap       = (cnt_inc == per_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= CNT_W'(1);
      per_q  <= CNT_W'(2);
      high_q <= CNT_W'(1);
      wave_q <= 1'b0;
    end else if (wrap) begin
      cnt_q  <= '0;
      per_q  <= new_period;
      high_q <= new_high;
      wave_q <= 1'b1;
    end else begin
      cnt_q  <= cnt_inc;
      wave_q <= (cnt_inc < high_q);
    end
  end

  assign wave        = wave_q;
  assign period_live = per_q;

endmodule

// File: rtl/clkdiv_gate.sv
module clkdiv_gate (
  input  logic clk,
  input  logic rst,
  input  logic gate_req,
  input  logic wave,
  output logic gate_live,
  output logic clk_out
);

  logic live_q;
  logic out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      live_q <= 1'b0;
      out_q  <= 1'b0;
    end else begin
      if (!wave) live_q <= gate_req;
      out_q <= wave & live_q;
    end
  end

  assign gate_live = live_q;
  assign clk_out   = out_q;

endmodule

// File: rtl/clkdiv_cell.sv
module clkdiv_cell
  import clkdiv_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [1:0]               wr_addr,
  input  logic [DW-1:0]            wr_data,
  input  logic                     rd_en,
  input  logic [1:0]               rd_addr,
  output logic [DW-1:0]            rd_data,
  output logic [3:0]               src_index,
  output logic                     clk_out
);

  div_cfg_t         cfg_w;
  logic             gate_req_w;
  logic             div_wave;
  logic             gate_live;
  logic [CNT_W-1:0] period_live;

  clkdiv_regs #(.DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_en     (rd_en),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .cfg       (cfg_w),
    .gate_req  (gate_req_w),
    .src_index (src_index)
  );

  clkdiv_core u_core (
    .clk         (clk),
    .rst         (rst),
    .cfg         (cfg_w),
    .wave        (div_wave),
    .period_live (period_live)
  );

  clkdiv_gate u_gate (
    .clk       (clk),
    .rst       (rst),
    .gate_req  (gate_req_w),
    .wave      (div_wave),
    .gate_live (gate_live),
    .clk_out   (clk_out)
  );

endmodule

// File: rtl/clkdiv_cell_chk.sv
module clkdiv_cell_chk
  import clkdiv_pkg::*;
#(
  parameter int DW = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wr_en,
  input logic [1:0]       wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic [3:0]       src_index,
  input logic             clk_out,
  input logic             div_wave,
  input logic             gate_live,
  input logic [CNT_W-1:0] period_live
);

  AST_IDX_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_IDX && wr_data <= DW'(IDX_MAX))
      ##1 !(wr_en && (wr_addr == ADDR_IDX || wr_addr == ADDR_SRC))
      |=> (src_index == 4'($past(wr_data, 2)))); // R9

  AST_GATE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !gate_live |=> !clk_out); // R7

  AST_GATE_SWITCH_LOW: assert property (@(posedge clk) disable iff (rst)
    $changed(gate_live) |-> !$past(div_wave)); // R7

  AST_RATIO_AT_RISE: assert property (@(posedge clk) disable iff (rst)
    $changed(period_live) |-> div_wave); // R6

  AST_THIRD_SHAPE: assert property (@(posedge clk) disable iff (rst)
    ($rose(div_wave) && period_live == CNT_W'(6)) |=> div_wave ##1 !div_wave); // R3

endmodule

bind clkdiv_cell clkdiv_cell_chk #(.DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .wr_en       (wr_en),
  .wr_addr     (wr_addr),
  .wr_data     (wr_data),
  .src_index   (src_index),
  .clk_out     (clk_out),
  .div_wave    (div_wave),
  .gate_live   (gate_live),
  .period_live (period_live)
);

// File: tb/clkdiv_cell_test.sv
module clkdiv_cell_test;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [1:0]    wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          rd_en = 1'b0;
  logic [1:0]    rd_addr = '0;
  logic [DW-1:0] rd_data;
  logic [3:0]    src_index;
  logic          clk_out;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  clkdiv_cell #(.DW(DW)) uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .src_index(src_index), .clk_out(clk_out)
  );

  function automatic int exp_ratio(input bit third, input bit on, input int code);
    int tbl[8] = '{1, 2, 4, 6, 8, 12, 1, 1};
    if (third) return 3;
    if (!on) return 1;
    return tbl[code];
  endfunction

  function automatic int exp_high(input int n);
    return (n == 3) ? 2 : n;
  endfunction

  function automatic logic [7:0] div_word(input bit third, input int code, input bit on);
    return {3'b000, third, 3'(code), on};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data;
  endtask

  task automatic wait_rise();
    logic p;
    p = clk_out;
    forever begin
      @(negedge clk);
      if (!p && clk_out) break;
      p = clk_out;
    end
  endtask

  task automatic measure(output int hi, output int lo);
    wait_rise(); wait_rise(); wait_rise();
    hi = 1;
    forever begin @(negedge clk); if (clk_out) hi++; else break; end
    lo = 1;
    forever begin @(negedge clk); if (!clk_out) lo++; else break; end
  endtask

  task automatic check_div(input string req, input bit third, input int code, input bit on);
    int hi, lo, n;
    wr(2'd1, div_word(third, code, on));
    measure(hi, lo);
    n = exp_ratio(third, on, code);
    chk({req, " high"}, hi, exp_high(n));
    chk({req, " low"}, lo, 2 * n - exp_high(n));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int highs, hi;
    bit m_on;
    int m_code;
    void'($urandom(32'd4242));

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk("R1 src_index", int'(src_index), 0);
    chk("R1 rd_data", int'(rd_data), 0);
    highs = 0;
    for (int i = 0; i < 30; i++) begin @(negedge clk); if (clk_out) highs++; end
    chk("R1 clk_out low", highs, 0);
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), d);
      chk("R1 field reads zero", int'(d), 0);
    end

    wr(2'd2, 8'h01);
    // R4: bypass at reset settings and with a nonzero code
    check_div("R4 bypass code0", 1'b0, 0, 1'b0);
    check_div("R4 bypass code5", 1'b0, 5, 1'b0);

    // R2 / R5: every table code
    for (int c = 0; c < 8; c++) check_div("R2 R5 table code", 1'b0, c, 1'b1);

    // R3: divide-by-three dominates
    check_div("R3 third over code5", 1'b1, 5, 1'b1);
    check_div("R3 third over bypass", 1'b1, 2, 1'b0);

    // R6: change during a long high phase
    wr(2'd1, div_word(1'b0, 5, 1'b1));
    wait_rise(); wait_rise();
    wait_rise();
    hi = 1;
    wr_en = 1'b1; wr_addr = 2'd1; wr_data = div_word(1'b0, 1, 1'b1);
    forever begin
      @(negedge clk);
      wr_en = 1'b0;
      if (clk_out) hi++; else break;
    end
    chk("R6 old high phase kept", hi, 12);
    check_div("R6 new ratio applied", 1'b0, 1, 1'b1);

    // R7: gate off holds low, on gives full pulses
    wr(2'd1, div_word(1'b0, 2, 1'b1));
    wr(2'd2, 8'h00);
    repeat (10) @(negedge clk);
    highs = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (clk_out) highs++; end
    chk("R7 gated output low", highs, 0);
    rd(2'd2, d);
    chk("R10 gate readback", int'(d), 0);
    wr(2'd2, 8'h01);
    check_div("R7 re-enabled pulses", 1'b0, 2, 1'b1);

    // R8: source decode
    wr(2'd0, 8'h0B);
    @(negedge clk);
    chk("R8 index from code5", int'(src_index), 6);
    wr(2'd0, 8'h0A);
    @(negedge clk);
    chk("R8 index with bit clear", int'(src_index), 0);
    rd(2'd0, d);
    chk("R10 source readback", int'(d), 8'h0A);
    rd(2'd1, d);
    chk("R10 divider readback", int'(d), int'(div_word(1'b0, 2, 1'b1)));

    // R9: index writes
    wr(2'd0, 8'h0F);
    wr(2'd3, 8'd0);
    rd(2'd0, d);
    chk("R9 zero keeps code", int'(d), 8'h0E);
    chk("R9 zero index", int'(src_index), 0);
    wr(2'd3, 8'd8);
    @(negedge clk);
    chk("R9 index 8", int'(src_index), 8);
    wr(2'd3, 8'd3);
    rd(2'd0, d);
    chk("R9 index 3 fields", int'(d), 8'h05);
    wr(2'd3, 8'd9);
    rd(2'd0, d);
    chk("R9 index 9 ignored", int'(d), 8'h05);
    rd(2'd3, d);
    chk("R10 index readback", int'(d), 3);

    // random divider settings
    for (int i = 0; i < 16; i++) begin
      bit t, o;
      int c;
      t = ($urandom % 4) == 0;
      o = $urandom % 2;
      c = $urandom % 8;
      check_div(t ? "R3 random" : (o ? "R2 random" : "R4 random"), t, c, o);
    end

    // random index writes against a model
    m_on = 1'b1; m_code = 2;
    for (int i = 0; i < 12; i++) begin
      int v;
      v = $urandom % 12;
      wr(2'd3, 8'(v));
      if (v == 0) m_on = 1'b0;
      else if (v <= 8) begin m_on = 1'b1; m_code = v - 1; end
      @(negedge clk);
      chk("R9 random index", int'(src_index), m_on ? m_code + 1 : 0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule